// File: doc/BRIEF.md
# Interrupt Request Flag Register

This block is an eight-bit control and status register that sits between a small microcontroller core and its interrupt controller. It keeps one pending-request flag for each of two timer overflow sources and for each of two active-low external interrupt pins. For every external pin it also keeps a mode bit that picks the sensing style. In edge mode a falling edge latches a request. In level mode the flag is a live, synchronized image of the pin, so it is asserted while the pin is low. Two timer run bits are plain storage that is handed on to the timers.

The core reads the whole register on `rd_data` and overwrites it with a one-cycle `wr_en` strobe. When the core vectors to a source, it sends a one-cycle acknowledge with a 2-bit source code. The acknowledge clears that source's flag, but only if the flag is latched: any timer flag, or an external flag in edge mode.

Each external channel is a four-state machine: LVL_IDLE, LVL_ACT, EDG_IDLE and EDG_PEND. Its transitions are:

- **track**: between LVL_IDLE and LVL_ACT, following the synchronized pin.
- **enter_edge**: from a level state to EDG_IDLE or EDG_PEND, on a write that selects edge mode.
- **enter_level**: from an edge state to LVL_IDLE or LVL_ACT, on a write that selects level mode.
- **latch**: to EDG_PEND, on a detected falling edge.
- **ack_clear**: EDG_PEND to EDG_IDLE, on an acknowledge.
- **sw_write**: between EDG_IDLE and EDG_PEND, on a write.

Each timer channel has two states, TMR_IDLE and TMR_PEND. Its transitions are:

- **overflow**: to TMR_PEND.
- **ack_clear**: to TMR_IDLE.
- **sw_write**: to either state.

Top module: `irq_flag_reg`

## Requirements
- R1: After reset, `rd_data` is 8'h00, `irq_req` is 0 and `tmr_run` is 0.
- R2: Register bits: 0 = external-0 mode, 1 = external-0 flag, 2 = external-1 mode, 3 = external-1 flag, 4 = timer-0 run, 5 = timer-0 flag, 6 = timer-1 run, 7 = timer-1 flag. A write loads every stored bit on the next edge. A mode bit of 1 selects edge mode and 0 selects level mode. The run bits appear on `tmr_run[1:0]`.
- R3: In level mode the external flag equals the inverse of its pin. A pin change reaches `rd_data` on the third rising edge after it, because it passes a two-flop synchronizer and then the flag register. In this mode, acknowledges and written flag values have no effect.
- R4: In edge mode, an acknowledge with code 0 (external 0) or code 2 (external 1) clears that external flag on the next edge.
- R5: In edge mode, a synchronized falling edge (previous sample 1, current sample 0) sets the flag on the third rising edge after the pin falls. A steady low pin or a rising edge never sets it.
- R6: A one-cycle `tmr_ovf[k]` pulse sets the timer-k flag on the next edge.
- R7: An acknowledge with code 1 (timer 0) or code 3 (timer 1) clears that timer flag on the next edge.
- R8: If a set event (overflow or detected falling edge) arrives in the same cycle as an acknowledge or a write of 0 to that flag, the flag ends set.
- R9: `irq_req[c]` is the flag of source code c: 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1. An acknowledge changes only the flag its code names, and has no effect while `ack_valid` is low.
- R10: If an acknowledge and a write of 1 to the same latched flag arrive in the same cycle, with no set event, the flag ends cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_n | input | 2 | Active-low external interrupt pins, asynchronous |
| tmr_ovf | input | 2 | One-cycle timer overflow pulses |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| ack_valid | input | 1 | One-cycle vector acknowledge |
| ack_src | input | 2 | Acknowledged source code |
| rd_data | output | 8 | Register contents |
| irq_req | output | 4 | Request lines, indexed by source code |
| tmr_run | output | 2 | Timer run bits |

## Verification
All 256 register values are written twice: once with both pins high and once with both pins held low. This separates latched edge-mode flags, which take the written value, from level-mode flags, which ignore it and show the pin. An acknowledge sweep over every source code, starting from an all-ones register, shows that exactly one flag clears per code and that no flag clears while `ack_valid` is low. Directed pin sequences count the three-edge latency in both modes, and they separate a falling edge from a steady low pin and from a rising edge. Same-cycle collisions show the priority order: a set beats an acknowledge, and an acknowledge beats a write.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

    // External channel: mode (level/edge) and flag encoded together
    typedef enum logic [1:0] {
        EXT_LVL_IDLE = 2'b00,
        EXT_LVL_ACT  = 2'b01,
        EXT_EDG_IDLE = 2'b10,
        EXT_EDG_PEND = 2'b11
    } ext_state_e;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_PEND = 1'b1
    } tmr_state_e;

    // Bit positions of channel k, for n channels
    function automatic int ext_mode_bit(int k);
        return 2 * k;
    endfunction

    function automatic int ext_flag_bit(int k);
        return 2 * k + 1;
    endfunction

    function automatic int tmr_run_bit(int k, int n);
        return 2 * n + 2 * k;
    endfunction

    function automatic int tmr_flag_bit(int k, int n);
        return 2 * n + 2 * k + 1;
    endfunction

    // Source codes: external k -> 2k, timer k -> 2k+1
    function automatic int ext_src_code(int k);
        return 2 * k;
    endfunction

    function automatic int tmr_src_code(int k);
        return 2 * k + 1;
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic level_low,
    output logic fell
);
    // chain_q[0] is the newest sample; chain_q[STAGES] is the previous
    // synchronized sample used for edge detection.
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], pin_n};
        end
    end

    assign level_low = ~chain_q[STAGES-1];
    assign fell      = chain_q[STAGES] & ~chain_q[STAGES-1];

endmodule

// File: rtl/irq_ext_chan.sv
module irq_ext_chan
    import irq_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_low,
    input  logic fell,
    input  logic ack_hit,
    input  logic wr_en,
    input  logic wr_mode,
    input  logic wr_flag,
    output logic mode,
    output logic flag
);
    ext_state_e state_q, state_d;
    ext_state_e edge_nx;
    ext_state_e level_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EXT_LVL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Candidate next states for each mode.
    // Edge priority: latch > ack_clear > sw_write > hold.
    always_comb begin
        if (fell) begin
            edge_nx = EXT_EDG_PEND;
        end else if (ack_hit) begin
            edge_nx = EXT_EDG_IDLE;
        end else if (wr_en) begin
            edge_nx = wr_flag ? EXT_EDG_PEND : EXT_EDG_IDLE;
        end else begin
            edge_nx = state_q;
        end
        level_nx = level_low ? EXT_LVL_ACT : EXT_LVL_IDLE;
    end

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EXT_LVL_IDLE, EXT_LVL_ACT: begin
                if (wr_en && wr_mode) begin
                    state_d = edge_nx;      // enter_edge
                end else begin
                    state_d = level_nx;     // track
                end
            end
            EXT_EDG_IDLE, EXT_EDG_PEND: begin
                if (wr_en && !wr_mode) begin
                    state_d = level_nx;     // enter_level
                end else begin
                    state_d = edge_nx;      // latch / ack_clear / sw_write
                end
            end
            default: state_d = EXT_LVL_IDLE;
        endcase
    end

    // Output process
    always_comb begin
        mode = 1'b0;
        flag = 1'b0;
        unique case (state_q)
            EXT_LVL_IDLE: begin mode = 1'b0; flag = 1'b0; end
            EXT_LVL_ACT:  begin mode = 1'b0; flag = 1'b1; end
            EXT_EDG_IDLE: begin mode = 1'b1; flag = 1'b0; end
            EXT_EDG_PEND: begin mode = 1'b1; flag = 1'b1; end
            default:      begin mode = 1'b0; flag = 1'b0; end
        endcase
    end

endmodule

// File: rtl/irq_tmr_chan.sv
module irq_tmr_chan
    import irq_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic ack_hit,
    input  logic wr_en,
    input  logic wr_flag,
    input  logic wr_run,
    output logic flag,
    output logic run
);
    tmr_state_e state_q, state_d;
    logic       run_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Run bit: plain storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (wr_en) begin
            run_q <= wr_run;
        end
    end

    // Next-state process: overflow > ack_clear > sw_write > hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_IDLE, TMR_PEND: begin
                if (ovf) begin
                    state_d = TMR_PEND;
                end else if (ack_hit) begin
                    state_d = TMR_IDLE;
                end else if (wr_en) begin
                    state_d = wr_flag ? TMR_PEND : TMR_IDLE;
                end
            end
            default: state_d = TMR_IDLE;
        endcase
    end

    // Output process
    always_comb begin
        flag = 1'b0;
        unique case (state_q)
            TMR_IDLE: flag = 1'b0;
            TMR_PEND: flag = 1'b1;
            default:  flag = 1'b0;
        endcase
        run = run_q;
    end

endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
    import irq_flag_pkg::*;
#(
    parameter  int NUM_CH      = 2,
    parameter  int SYNC_STAGES = 2,
    localparam int REG_W       = 4 * NUM_CH,
    localparam int SRC_N       = 2 * NUM_CH,
    localparam int SRC_W       = $clog2(SRC_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ext_pin_n,
    input  logic [NUM_CH-1:0] tmr_ovf,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              ack_valid,
    input  logic [SRC_W-1:0]  ack_src,
    output logic [REG_W-1:0]  rd_data,
    output logic [SRC_N-1:0]  irq_req,
    output logic [NUM_CH-1:0] tmr_run
);
    logic [NUM_CH-1:0] pin_low;
    logic [NUM_CH-1:0] pin_fell;
    logic [NUM_CH-1:0] ext_mode;
    logic [NUM_CH-1:0] ext_flag;
    logic [NUM_CH-1:0] tmr_flag;
    logic [NUM_CH-1:0] ack_ext;
    logic [NUM_CH-1:0] ack_tmr;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        localparam int MB = ext_mode_bit(k);
        localparam int FB = ext_flag_bit(k);
        localparam int RB = tmr_run_bit(k, NUM_CH);
        localparam int TB = tmr_flag_bit(k, NUM_CH);
        localparam logic [SRC_W-1:0] EXT_CODE = SRC_W'(ext_src_code(k));
        localparam logic [SRC_W-1:0] TMR_CODE = SRC_W'(tmr_src_code(k));

        assign ack_ext[k] = ack_valid && (ack_src == EXT_CODE);
        assign ack_tmr[k] = ack_valid && (ack_src == TMR_CODE);

        irq_pin_sync #(
            .STAGES(SYNC_STAGES)
        ) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_n    (ext_pin_n[k]),
            .level_low(pin_low[k]),
            .fell     (pin_fell[k])
        );

        irq_ext_chan u_ext (
            .clk      (clk),
            .rst_n    (rst_n),
            .level_low(pin_low[k]),
            .fell     (pin_fell[k]),
            .ack_hit  (ack_ext[k]),
            .wr_en    (wr_en),
            .wr_mode  (wr_data[MB]),
            .wr_flag  (wr_data[FB]),
            .mode     (ext_mode[k]),
            .flag     (ext_flag[k])
        );

        irq_tmr_chan u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .ovf    (tmr_ovf[k]),
            .ack_hit(ack_tmr[k]),
            .wr_en  (wr_en),
            .wr_flag(wr_data[TB]),
            .wr_run (wr_data[RB]),
            .flag   (tmr_flag[k]),
            .run    (tmr_run[k])
        );

        assign rd_data[MB]           = ext_mode[k];
        assign rd_data[FB]           = ext_flag[k];
        assign rd_data[RB]           = tmr_run[k];
        assign rd_data[TB]           = tmr_flag[k];
        assign irq_req[ext_src_code(k)] = ext_flag[k];
        assign irq_req[tmr_src_code(k)] = tmr_flag[k];
    end

endmodule

// File: rtl/irq_flag_reg_chk.sv
module irq_flag_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] ext_pin_n,
    input logic [1:0] tmr_ovf,
    input logic       wr_en,
    input logic [1:0] run_wr,
    input logic       ack_valid,
    input logic [1:0] ack_src,
    input logic [7:0] rd_data
);
    // Cycles since reset, saturating; guards $past windows on the pins
    logic [2:0] age_q;
    logic       age_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 3'd7) begin
            age_q <= age_q + 3'd1;
        end
    end
    assign age_ok = (age_q >= 3'd5);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == 8'h00));

    assert_run_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ({rd_data[6], rd_data[4]} == $past(run_wr)));

    assert_level_tracks_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (age_ok && !wr_en && !rd_data[0]) |=> (rd_data[1] == !$past(ext_pin_n[0], 3)));

    assert_edge_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (age_ok && !wr_en && rd_data[0] && ack_valid && ack_src == 2'd0
         && $past(ext_pin_n[0], 2)) |=> !rd_data[1]);

    assert_edge_fall_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_ok && !wr_en && rd_data[2] && $past(ext_pin_n[1], 3)
         && !$past(ext_pin_n[1], 2)) |=> rd_data[3]);

    assert_ovf_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf[1] |=> rd_data[7]);

    assert_tmr_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_ovf[0] && !wr_en && ack_valid && ack_src == 2'd1) |=> !rd_data[5]);

    assert_set_beats_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_ovf[0] && ack_valid && ack_src == 2'd1) |=> rd_data[5]);

    assert_ack_beats_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_ovf[1] && wr_en && ack_valid && ack_src == 2'd3) |=> !rd_data[7]);

endmodule

bind irq_flag_reg irq_flag_reg_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_pin_n(ext_pin_n),
    .tmr_ovf  (tmr_ovf),
    .wr_en    (wr_en),
    .run_wr   ({wr_data[6], wr_data[4]}),
    .ack_valid(ack_valid),
    .ack_src  (ack_src),
    .rd_data  (rd_data)
);

// File: tb/irq_flag_reg_test.sv
`timescale 1ns/1ps
module irq_flag_reg_test;
    logic       clk       = 1'b0;
    logic       rst_n     = 1'b0;
    logic [1:0] pin_n     = 2'b11;
    logic [1:0] ovf       = 2'b00;
    logic       wr_en     = 1'b0;
    logic [7:0] wr_data   = 8'h00;
    logic       ack_valid = 1'b0;
    logic [1:0] ack_src   = 2'd0;
    logic [7:0] rd_data;
    logic [3:0] irq_req;
    logic [1:0] tmr_run;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    irq_flag_reg uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_pin_n(pin_n),
        .tmr_ovf  (ovf),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ack_valid(ack_valid),
        .ack_src  (ack_src),
        .rd_data  (rd_data),
        .irq_req  (irq_req),
        .tmr_run  (tmr_run)
    );

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Flag bit of a source code: even codes -> code+1, odd codes -> code+4
    function automatic logic [7:0] flag_mask(int code);
        return (code % 2 == 0) ? 8'(1 << (code + 1)) : 8'(1 << (code + 4));
    endfunction

    // Expected readback after writing v with the given steady pin levels
    function automatic logic [7:0] write_exp(logic [7:0] v, logic [1:0] pins);
        logic [7:0] e = v;
        if (!v[0]) e[1] = !pins[0];
        if (!v[2]) e[3] = !pins[1];
        return e;
    endfunction

    function automatic logic [3:0] req_of(logic [7:0] r);
        return {r[7], r[3], r[5], r[1]};
    endfunction

    task automatic check_all(string tag, logic [7:0] exp);
        check(tag, 16'(rd_data), 16'(exp));
        check({tag, " R9 req"}, 16'(irq_req), 16'(req_of(exp)));
        check({tag, " R2 run"}, 16'(tmr_run), 16'({exp[6], exp[4]}));
    endtask

    task automatic wr(logic [7:0] v);
        wr_data = v;
        wr_en   = 1'b1;
        step();
        wr_en   = 1'b0;
    endtask

    task automatic ack(int code);
        ack_valid = 1'b1;
        ack_src   = 2'(code);
        step();
        ack_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        check_all("R1 reset", 8'h00);
        step(5);

        // R2/R3: all values, pins high
        for (int v = 0; v < 256; v++) begin
            wr(8'(v));
            check_all("R2 sweep pins high", write_exp(8'(v), 2'b11));
        end

        // R2/R3: all values, pins held low (steady, no fresh edge)
        pin_n = 2'b00;
        step(5);
        for (int v = 0; v < 256; v++) begin
            wr(8'(v));
            check_all("R3 sweep pins low", write_exp(8'(v), 2'b00));
        end
        pin_n = 2'b11;
        step(5);

        // R4/R7/R9: acknowledge each code from all-ones
        for (int c = 0; c < 4; c++) begin
            wr(8'hFF);
            ack(c);
            check_all((c % 2 == 0) ? "R4 ack ext" : "R7 ack tmr", 8'hFF & ~flag_mask(c));
        end
        wr(8'hFF);
        ack_src = 2'd1;
        step();
        check_all("R9 ack not valid", 8'hFF);

        // R3: level mode latency, ack and write ignored
        wr(8'h00);
        pin_n[0] = 1'b0;
        step(2);
        check("R3 level before 3rd edge", 16'(rd_data), 16'h00);
        step();
        check("R3 level after 3rd edge", 16'(rd_data), 16'h02);
        ack(0);
        check("R3 level ack ignored", 16'(rd_data), 16'h02);
        wr(8'h00);
        check("R3 level write ignored", 16'(rd_data), 16'h02);
        pin_n[0] = 1'b1;
        step(2);
        check("R3 level release early", 16'(rd_data), 16'h02);
        step();
        check("R3 level release", 16'(rd_data), 16'h00);

        // R5/R4: edge mode on external 1
        wr(8'h05);
        pin_n[1] = 1'b0;
        step(2);
        check("R5 edge before 3rd edge", 16'(rd_data), 16'h05);
        step();
        check_all("R5 edge latched", 8'h0D);
        ack(2);
        check("R4 edge ack clears", 16'(rd_data), 16'h05);
        step(3);
        check("R5 steady low no set", 16'(rd_data), 16'h05);
        pin_n[1] = 1'b1;
        step(5);
        check("R5 rising no set", 16'(rd_data), 16'h05);

        // R8: falling edge with ack and write-0 in the same cycle
        wr(8'h01);
        pin_n[0] = 1'b0;
        step(2);
        wr_data   = 8'h01;
        wr_en     = 1'b1;
        ack_valid = 1'b1;
        ack_src   = 2'd0;
        step();
        wr_en     = 1'b0;
        ack_valid = 1'b0;
        check("R8 edge set beats ack", 16'(rd_data), 16'h03);
        pin_n[0] = 1'b1;
        step(5);
        check("R5 rising keeps latch", 16'(rd_data), 16'h03);

        // R6: overflow pulses
        wr(8'h00);
        ovf = 2'b01;
        step();
        ovf = 2'b00;
        check("R6 tmr0 ovf", 16'(rd_data), 16'h20);
        ovf = 2'b10;
        step();
        ovf = 2'b00;
        check_all("R6 tmr1 ovf", 8'hA0);

        // R8: overflow against ack and against write 0
        wr(8'h00);
        ovf       = 2'b01;
        ack_valid = 1'b1;
        ack_src   = 2'd1;
        step();
        ovf       = 2'b00;
        ack_valid = 1'b0;
        check("R8 ovf beats ack", 16'(rd_data), 16'h20);
        ovf     = 2'b10;
        wr_data = 8'h00;
        wr_en   = 1'b1;
        step();
        ovf     = 2'b00;
        wr_en   = 1'b0;
        check("R8 ovf beats write", 16'(rd_data), 16'h80);

        // R10: ack beats write of 1
        wr(8'h20);
        wr_data   = 8'h20;
        wr_en     = 1'b1;
        ack_valid = 1'b1;
        ack_src   = 2'd1;
        step();
        wr_en     = 1'b0;
        ack_valid = 1'b0;
        check("R10 tmr0 ack beats write", 16'(rd_data), 16'h00);
        wr(8'h80);
        wr_data   = 8'h80;
        wr_en     = 1'b1;
        ack_valid = 1'b1;
        ack_src   = 2'd3;
        step();
        wr_en     = 1'b0;
        ack_valid = 1'b0;
        check("R10 tmr1 ack beats write", 16'(rd_data), 16'h00);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule